// File: doc/BRIEF.md
# Sideband Auxiliary Channel Transaction Sequencer

This block carries out one request/reply transaction on the sideband auxiliary channel of a display link. A host hands it a transaction type, a 20-bit address, a byte count from 1 to 16 and up to 16 bytes of write payload. The sequencer waits for the channel controller to go idle and then acquires it through a request/grant handshake. Next it checks that a sink is attached, stages the payload and launches the transaction. A failed attempt is retried after a controller reset and a settle delay. For a read, the reply bytes are returned.

All waits are counted in microseconds. A free-running prescaler of `CLK_PER_US` clock cycles derives each microsecond. The idle, grant and completion waits are each bounded by `TMO_US`, and retries wait `SETTLE_US` before they restart. When the sequencer finishes it pulses `done` for one cycle with a 2-bit result code: 0 = success, 1 = channel busy, 2 = no sink, 3 = remote error. The channel is released on every exit.

Top module: `aux_xact_seq`

## Requirements
- R1: After a request, the sequencer waits while `ch_busy` is high and does not raise `ch_req`. If `ch_busy` is still high after `TMO_US` microseconds, it finishes with result 1 (busy) and never raises `ch_req`.
- R2: Once idle, the sequencer holds `ch_req` high and waits for `ch_gnt`. If no grant comes within `TMO_US` microseconds, it finishes with result 1 and drops `ch_req`.
- R3: After the grant, if sink-present bit 28 of `ch_status` is clear, the sequencer finishes with result 2 and `ch_start` is never raised.
- R4: Bit 0 of the type selects direction (1 = read, 0 = write). For a write, `ch_wdata` carries the payload with byte k at bits 8k+7:8k, and bytes at or beyond the count are forced to zero. For a read, `ch_wdata` is all zero.
- R5: `ch_ctrl` holds the type in bits 15:12 and the count minus one in bits 3:0, with the other bits zero. `ch_addr` holds the request address.
- R6: Every attempt is preceded by a one-cycle `ch_rst` pulse. The first attempt raises `ch_start` in the cycle right after the pulse. Each later attempt raises it only after at least `SETTLE_US` microseconds.
- R7: `ch_start` stays high until `ch_done`. If `ch_done` does not arrive within `TMO_US` microseconds, the sequencer finishes with result 3 and makes no further attempt.
- R8: An attempt succeeds only when `ch_status` bits 19:16 and 11:8 are all zero at `ch_done`. Otherwise the sequencer retries, and after `MAX_TRIES` failed attempts it finishes with result 3.
- R9: On a successful read, `rdata` holds `ch_rdata` with bytes at or beyond the count zeroed. After a write, or after any failure, `rdata` is zero.
- R10: At `done`, `ch_req` and `ch_start` are low. `busy` is low only when the sequencer is idle, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start pulse, taken while idle |
| req_type | input | 4 | Transaction type, bit 0 = read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write payload, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 busy, 2 no sink, 3 remote error |
| rdata | output | 128 | Read reply, masked to the count |
| ch_req | output | 1 | Channel acquisition request |
| ch_rst | output | 1 | Controller reset pulse |
| ch_start | output | 1 | Start command, held until completion |
| ch_ctrl | output | 16 | Control word: type and count minus one |
| ch_addr | output | 20 | Address to controller |
| ch_wdata | output | 128 | Staged write payload |
| ch_busy | input | 1 | Controller busy or pending |
| ch_gnt | input | 1 | Acquisition grant |
| ch_done | input | 1 | Attempt finished pulse |
| ch_status | input | 32 | Status: bit 28 sink present, 19:16 and 11:8 errors |
| ch_rdata | input | 128 | Reply bytes from controller |

## Verification
The hardest case to reach from the ports is exhaustion of the retry budget. It needs every one of `MAX_TRIES` attempts to end with an error while each settle delay still elapses. The bench's behavioural responder can be told to fail a chosen number of attempts. It counts start edges and measures the gap from each reset pulse to the following start. A small clock divider and short waits let the full 32-attempt run, and each timeout path, finish in a few thousand cycles. Separate responder modes hold the channel busy, withhold the grant, hide the sink or never complete, which drives each timeout path on its own.

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter int CLK_PER_US = 100,
  parameter int TMO_US     = 1000,
  parameter int SETTLE_US  = 400,
  parameter int MAX_TRIES  = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [3:0]   req_type,
  input  logic [19:0]  req_addr,
  input  logic [4:0]   req_len,
  input  logic [127:0] req_wdata,
  output logic         busy,
  output logic         done,
  output logic [1:0]   result,
  output logic [127:0] rdata,
  output logic         ch_req,
  output logic         ch_rst,
  output logic         ch_start,
  output logic [15:0]  ch_ctrl,
  output logic [19:0]  ch_addr,
  output logic [127:0] ch_wdata,
  input  logic         ch_busy,
  input  logic         ch_gnt,
  input  logic         ch_done,
  input  logic [31:0]  ch_status,
  input  logic [127:0] ch_rdata
);
  localparam int US_MAX = (TMO_US > SETTLE_US) ? TMO_US : SETTLE_US;
  localparam int US_W   = $clog2(US_MAX + 1) + 1;
  localparam int PRE_W  = $clog2(CLK_PER_US + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_BUSY = 2'd1, RES_NOSINK = 2'd2, RES_REMOTE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WIDLE, S_WGNT, S_SINK, S_RST, S_SETTLE, S_START, S_FIN} st_t;

  st_t              state, state_n;
  logic [3:0]       typ;
  logic [4:0]       len;
  logic [1:0]       res_n;
  logic [TRY_W-1:0] tries;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic             tick, tmo, err, last_try;

  function automatic logic [127:0] len_mask(input logic [4:0] n);
    for (int i = 0; i < 16; i++) len_mask[i*8 +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
  endfunction

  assign tick     = (pre == PRE_W'(CLK_PER_US - 1));
  assign tmo      = (us >= US_W'(TMO_US));
  assign err      = (|ch_status[19:16]) | (|ch_status[11:8]);
  assign last_try = (tries == TRY_W'(MAX_TRIES - 1));

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign ch_req   = (state == S_WGNT) || (state == S_SINK) || (state == S_RST) ||
                    (state == S_SETTLE) || (state == S_START);
  assign ch_rst   = (state == S_RST);
  assign ch_start = (state == S_START);
  assign ch_ctrl  = {typ, 8'h00, 4'(len - 5'd1)};

  always_comb begin
    state_n = state;
    res_n   = result;
    case (state)
      S_IDLE:   if (req_valid) state_n = S_WIDLE;
      S_WIDLE:  if (!ch_busy) state_n = S_WGNT;
                else if (tmo) begin state_n = S_FIN; res_n = RES_BUSY; end
      S_WGNT:   if (ch_gnt) state_n = S_SINK;
                else if (tmo) begin state_n = S_FIN; res_n = RES_BUSY; end
      S_SINK:   if (ch_status[28]) state_n = S_RST;
                else begin state_n = S_FIN; res_n = RES_NOSINK; end
      S_RST:    state_n = (tries != '0) ? S_SETTLE : S_START;
      S_SETTLE: if (us >= US_W'(SETTLE_US)) state_n = S_START;
      S_START:  if (ch_done) begin
                  if (!err) begin state_n = S_FIN; res_n = RES_OK; end
                  else if (last_try) begin state_n = S_FIN; res_n = RES_REMOTE; end
                  else state_n = S_RST;
                end else if (tmo) begin state_n = S_FIN; res_n = RES_REMOTE; end
      default:  state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      us  <= '0;
    end else if (state == S_IDLE || state_n != state) begin
      pre <= '0;
      us  <= '0;
    end else if (tick) begin
      pre <= '0;
      if (us <= US_W'(US_MAX)) us <= us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      result   <= RES_OK;
      typ      <= '0;
      len      <= 5'd1;
      ch_addr  <= '0;
      ch_wdata <= '0;
      rdata    <= '0;
      tries    <= '0;
    end else begin
      state  <= state_n;
      result <= res_n;
      if (state == S_IDLE && req_valid) begin
        typ      <= req_type;
        len      <= req_len;
        ch_addr  <= req_addr;
        ch_wdata <= req_type[0] ? '0 : (req_wdata & len_mask(req_len));
        rdata    <= '0;
      end
      if (state == S_SINK) tries <= '0;
      if (state == S_START && ch_done) begin
        if (err && !last_try) tries <= tries + 1'b1;
        if (!err && typ[0]) rdata <= ch_rdata & len_mask(len);
      end
    end
  end

  a_r3_no_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SINK && !ch_status[28]) |=> (done && result == RES_NOSINK));

  a_r6_retry_settles: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_start) && tries != '0) |-> $past(state) == S_SETTLE);

  a_r8_ok_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> ($past(ch_done) && !$past(err)));

  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ch_req && !ch_start && busy));

  a_r1_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_BUSY) |-> ($past(state) == S_WIDLE || $past(state) == S_WGNT));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/aux_xact_seq_test.sv
module aux_xact_seq_test;
  localparam int CPU = 4, TMO = 25, SETTLE = 10, TRIES = 32;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0;
  logic [3:0] req_type = 0;
  logic [19:0] req_addr = 0;
  logic [4:0] req_len = 1;
  logic [127:0] req_wdata = 0;
  logic busy, done, ch_req, ch_rst, ch_start;
  logic [1:0] result;
  logic [127:0] rdata, ch_wdata;
  logic [15:0] ch_ctrl;
  logic [19:0] ch_addr;
  logic ch_busy = 0, ch_gnt = 0, ch_done = 0;
  logic [31:0] ch_status = 0;
  logic [127:0] ch_rdata = 128'h8899aabbccddeeff_0123456789abcdef;

  aux_xact_seq #(.CLK_PER_US(CPU), .TMO_US(TMO), .SETTLE_US(SETTLE), .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .busy(busy), .done(done), .result(result),
    .rdata(rdata), .ch_req(ch_req), .ch_rst(ch_rst), .ch_start(ch_start), .ch_ctrl(ch_ctrl),
    .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_busy(ch_busy), .ch_gnt(ch_gnt),
    .ch_done(ch_done), .ch_status(ch_status), .ch_rdata(ch_rdata));

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural responder
  bit no_grant = 0, sink = 1, hang = 0, err_hi = 0;
  int fail_n = 0, attempts = 0, cyc = 0, rst_cyc = 0, first_gap = 0, min_gap = 0, max_gap = 0;
  int lat = 0, req_seen = 0;
  logic start_q = 0;
  logic [15:0] cap_ctrl;
  logic [19:0] cap_addr;
  logic [127:0] cap_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    start_q <= ch_start;
    ch_gnt <= ch_req && !no_grant;
    ch_done <= 0;
    if (ch_req) req_seen <= req_seen + 1;
    ch_status[28] <= sink;
    if (ch_rst) rst_cyc <= cyc;
    if (ch_start && !start_q) begin
      if (attempts == 0) first_gap <= cyc - rst_cyc;
      else begin
        if (min_gap == 0 || cyc - rst_cyc < min_gap) min_gap <= cyc - rst_cyc;
        if (cyc - rst_cyc > max_gap) max_gap <= cyc - rst_cyc;
      end
      attempts <= attempts + 1;
      cap_ctrl <= ch_ctrl; cap_addr <= ch_addr; cap_wdata <= ch_wdata;
      lat <= hang ? 0 : 3;
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        ch_done <= 1;
        ch_status[19:16] <= (attempts <= fail_n && err_hi) ? 4'h2 : 4'h0;
        ch_status[11:8]  <= (attempts <= fail_n && !err_hi) ? 4'h1 : 4'h0;
      end
    end
  end

  // scoreboard
  logic [129:0] expq[$];
  bit seen = 0;
  always @(negedge clk) if (rst_n && done) begin
    logic [129:0] e;
    if (expq.size() == 0) chk(0, "R10 unexpected done", 0, 0);
    else begin
      e = expq.pop_front();
      chk(result == e[129:128], "R8 result", 128'(result), 128'(e[129:128]));
      chk(rdata == e[127:0], "R9 rdata", rdata, e[127:0]);
      chk(!ch_req && !ch_start, "R10 release at done", {ch_req, ch_start}, 0);
    end
    seen = 1;
  end

  function automatic logic [127:0] keep(input logic [127:0] d, input int n);
    keep = '0;
    for (int b = 0; b < n; b++) keep[b*8 +: 8] = d[b*8 +: 8];
  endfunction

  task automatic run(input logic [3:0] t, input logic [19:0] a, input int n, input logic [127:0] w,
                     input logic [1:0] er, input logic [127:0] ed);
    expq.push_back({er, ed});
    attempts = 0; first_gap = 0; min_gap = 0; max_gap = 0; req_seen = 0; seen = 0;
    @(negedge clk);
    req_valid = 1; req_type = t; req_addr = a; req_len = 5'(n); req_wdata = w;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R10 busy after request", 128'(busy), 1);
    while (!seen) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", {busy, done}, 0);
  endtask

  localparam logic [127:0] WP = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !ch_req && !ch_start && !done, "R10 reset state", {busy, ch_req, ch_start, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(4'h8, 20'h00100, 5, WP, 2'd0, 0);
    chk(cap_wdata == keep(WP, 5), "R4 write staging", cap_wdata, keep(WP, 5));
    chk(cap_ctrl == 16'h8004, "R5 ctrl word", 128'(cap_ctrl), 128'h8004);
    chk(cap_addr == 20'h00100, "R5 address", 128'(cap_addr), 128'h100);
    chk(attempts == 1 && first_gap == 1, "R6 first attempt", 128'({attempts, first_gap}), 128'({32'd1, 32'd1}));

    run(4'h9, 20'habcde, 16, WP, 2'd0, ch_rdata);
    chk(cap_wdata == 0, "R4 read stages zero", cap_wdata, 0);
    chk(cap_ctrl == 16'h900f, "R5 ctrl read 16", 128'(cap_ctrl), 128'h900f);

    run(4'h9, 20'h00200, 3, 0, 2'd0, keep(ch_rdata, 3));

    fail_n = 2;
    run(4'h1, 20'h00050, 1, 0, 2'd0, keep(ch_rdata, 1));
    chk(attempts == 3, "R8 retry count", 128'(attempts), 3);
    chk(min_gap >= SETTLE*CPU + 1 && max_gap <= SETTLE*CPU + 6, "R6 settle gap",
        128'({min_gap, max_gap}), 128'(SETTLE*CPU + 1));

    fail_n = 100; err_hi = 1;
    run(4'h9, 20'h00060, 4, 0, 2'd3, 0);
    chk(attempts == TRIES, "R8 attempt limit", 128'(attempts), 128'(TRIES));
    fail_n = 0; err_hi = 0;

    sink = 0;
    run(4'h8, 20'h00070, 2, WP, 2'd2, 0);
    chk(attempts == 0, "R3 no start without sink", 128'(attempts), 0);
    sink = 1;

    ch_busy = 1;
    run(4'h8, 20'h00080, 2, WP, 2'd1, 0);
    chk(req_seen == 0, "R1 no request while busy", 128'(req_seen), 0);
    ch_busy = 0;

    no_grant = 1;
    run(4'h8, 20'h00090, 2, WP, 2'd1, 0);
    chk(req_seen >= TMO*CPU && attempts == 0, "R2 grant timeout", 128'(req_seen), 128'(TMO*CPU));
    no_grant = 0;

    hang = 1;
    run(4'h9, 20'h000a0, 8, 0, 2'd3, 0);
    chk(attempts == 1, "R7 no retry after hang", 128'(attempts), 1);
    hang = 0;

    run(4'h8, 20'h000b0, 16, WP, 2'd0, 0);
    chk(cap_wdata == WP, "R4 full payload", cap_wdata, WP);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule